// File: doc/BRIEF.md
# Audio Clock Regeneration N/CTS Generator

This block produces the N and CTS numbers a display link transmitter sends so that the sink can rebuild the audio sample clock from the link pixel clock. Software loads a 20-bit N through byte-wide register writes. The block then forms a measurement window lasting N/128 audio sample periods in the audio reference clock domain. It counts pixel clock cycles across each window. That count is CTS, which equals pixel_clock × N / (128 × fs).

A window-end event crosses from the audio domain to the pixel domain as a toggle. In the pixel domain it latches the running count as CTS and restarts the count. In manual mode the block reports a value that software supplies in place of the measured count. A halve-N control can shift N right by one bit before it is used. Each new pair is presented to the packet builder with a single-cycle strobe, and the pair holds steady until the next strobe.

The audio reference clock runs at FS_MULT times the sample rate. The default of 64 matches a 44.1 kHz, 64× setup.

Top module: `acr_nc_gen`

## Requirements
- R1: N low byte is written at 0x3200, middle byte at 0x3201, and bits 19..16 at 0x3202 wdata[3:0]. The low and middle bytes are only staged. The full N takes effect when 0x3202 is written.
- R2: 0x3205 is the control byte: [3:0] manual CTS bits 19..16, bit 4 manual enable, bit 5 halve N. Manual CTS bits 7..0 are staged at 0x3203 and bits 15..8 at 0x3204. All control fields take effect together on the 0x3205 write.
- R3: The effective N is N>>1 when halve N is set, and N otherwise. acr_n presents the effective N.
- R4: One window lasts N_eff × FS_MULT / 128 audio clock cycles, which is N_eff / 128 sample periods.
- R5: In automatic mode acr_cts equals the number of pixel clock cycles between consecutive window ends.
- R6: In manual mode acr_cts equals the manual CTS value, and the window timing still paces the strobes.
- R7: acr_valid is high for exactly one pixel cycle per reported window. acr_n and acr_cts hold their values between strobes.
- R8: The first three window ends after reset or after any commit (R1/R2) produce no strobe. This discards windows that were not fully measured.
- R9: An effective window length of zero audio cycles stops the windows, and no strobe is issued.
- R10: After reset acr_n and acr_cts are zero and acr_valid is low.
- R11: Writes to any address other than 0x3200 to 0x3205 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel (TMDS) clock |
| rst_pix | input | 1 | Synchronous active-high reset, pixel domain |
| clk_aud | input | 1 | Audio reference clock, FS_MULT × fs |
| rst_aud | input | 1 | Synchronous active-high reset, audio domain |
| reg_we | input | 1 | Register write strobe (pixel domain) |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| acr_n | output | 20 | Effective N for the packet |
| acr_cts | output | 20 | CTS for the packet |
| acr_valid | output | 1 | One-cycle strobe marking a new N/CTS pair |

## Verification
The clocks are in a fixed rational ratio with a phase offset, so the measured CTS is exact. The patterns cover several N values: powers of two, a non-power of two, and a value using the middle byte. Each one shows that CTS scales linearly with N and not with a fixed count. A large N with halving set is compared against the plain N it reduces to, which isolates the shift. A manual pattern with a non-round value shows that the software value replaces the measurement while the strobe pacing continues. Directed cases separate staged writes from committed ones, stray addresses from decoded ones, a zero-length window from a slow one, and the startup discard from an early report.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int N_W   = 20;
    localparam int CTS_W = 20;

    localparam logic [15:0] ADDR_N_LO   = 16'h3200;
    localparam logic [15:0] ADDR_N_MID  = 16'h3201;
    localparam logic [15:0] ADDR_N_HI   = 16'h3202;
    localparam logic [15:0] ADDR_MC_LO  = 16'h3203;
    localparam logic [15:0] ADDR_MC_MID = 16'h3204;
    localparam logic [15:0] ADDR_CTRL   = 16'h3205;

    localparam int CTRL_MANUAL_BIT = 4;
    localparam int CTRL_HALVE_BIT  = 5;

    typedef logic [N_W-1:0]   n_val_t;
    typedef logic [CTS_W-1:0] cts_val_t;

    typedef struct packed {
        logic     manual;
        logic     halve;
        cts_val_t mcts;
    } acr_cfg_t;

    function automatic n_val_t eff_n(input n_val_t n, input logic halve);
        return halve ? (n >> 1) : n;
    endfunction

endpackage

// File: rtl/acr_regfile.sv
module acr_regfile
    import acr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output n_val_t      n_cur,
    output acr_cfg_t    cfg,
    output logic        commit
);
    logic [7:0] n_lo_q, n_mid_q, mc_lo_q, mc_mid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_lo_q   <= '0;
            n_mid_q  <= '0;
            mc_lo_q  <= '0;
            mc_mid_q <= '0;
            n_cur    <= '0;
            cfg      <= '0;
            commit   <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (we) begin
                case (addr)
                    ADDR_N_LO:   n_lo_q   <= wdata;
                    ADDR_N_MID:  n_mid_q  <= wdata;
                    ADDR_MC_LO:  mc_lo_q  <= wdata;
                    ADDR_MC_MID: mc_mid_q <= wdata;
                    ADDR_N_HI: begin
                        n_cur  <= {wdata[3:0], n_mid_q, n_lo_q};
                        commit <= 1'b1;
                    end
                    ADDR_CTRL: begin
                        cfg.manual <= wdata[CTRL_MANUAL_BIT];
                        cfg.halve  <= wdata[CTRL_HALVE_BIT];
                        cfg.mcts   <= {wdata[3:0], mc_mid_q, mc_lo_q};
                        commit     <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: the active N moves only after a write to the top byte
    assert_n_commit_only_top_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(n_cur) |-> $past(we && addr == ADDR_N_HI));

    // R2: control fields move only after a write to the control byte
    assert_cfg_commit_only_ctrl_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> $past(we && addr == ADDR_CTRL));

endmodule

// File: rtl/acr_win_div.sv
module acr_win_div
    import acr_pkg::*;
#(
    parameter int FS_MULT = 64
) (
    input  logic   clk,
    input  logic   rst,
    input  n_val_t n_eff_async,
    output logic   tog
);
    localparam int SHR = $clog2(128) - $clog2(FS_MULT);

    n_val_t n_s1, n_s2;
    n_val_t win_q, cnt_q;
    n_val_t win_next;

    assign win_next = n_s2 >> SHR;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_s1  <= '0;
            n_s2  <= '0;
            win_q <= '0;
            cnt_q <= '0;
            tog   <= 1'b0;
        end else begin
            n_s1 <= n_eff_async;
            n_s2 <= n_s1;
            if (win_q == '0) begin
                cnt_q <= '0;
                win_q <= win_next;
            end else if (cnt_q >= win_q - 1'b1) begin
                cnt_q <= '0;
                tog   <= ~tog;
                win_q <= win_next;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4: the window count never runs past the loaded length
    assert_win_count_range_R4: assert property (@(posedge clk) disable iff (rst)
        (win_q != '0) |-> (cnt_q < win_q));

    // R9: an idle divider never ends a window
    assert_idle_no_toggle_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(win_q) == '0) |-> $stable(tog));

endmodule

// File: rtl/acr_pulse_sync.sv
module acr_pulse_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_in,
    output logic pulse
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], tog_in};
    end

    assign pulse = sh_q[STAGES-1] ^ sh_q[STAGES-2];

endmodule

// File: rtl/acr_cts_meas.sv
module acr_cts_meas
    import acr_pkg::*;
#(
    parameter int DISCARD = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     win_end,
    input  logic     commit,
    input  n_val_t   n_eff,
    input  logic     manual,
    input  cts_val_t mcts,
    output n_val_t   acr_n,
    output cts_val_t acr_cts,
    output logic     acr_valid
);
    localparam int SKIP_W = $clog2(DISCARD + 1);
    localparam cts_val_t CNT_MAX = '1;

    cts_val_t          cnt_q;
    logic [SKIP_W-1:0] skip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            skip_q    <= SKIP_W'(DISCARD);
            acr_n     <= '0;
            acr_cts   <= '0;
            acr_valid <= 1'b0;
        end else begin
            acr_valid <= 1'b0;
            if (win_end) begin
                cnt_q <= '0;
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (commit) begin
                skip_q <= SKIP_W'(DISCARD);
            end else if (win_end) begin
                if (skip_q != '0) begin
                    skip_q <= skip_q - 1'b1;
                end else begin
                    acr_valid <= 1'b1;
                    acr_n     <= n_eff;
                    acr_cts   <= manual ? mcts : cnt_q + 1'b1;
                end
            end
        end
    end

    // R7: strobe lasts a single cycle
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        acr_valid |=> !acr_valid);

    // R7: the pair holds between strobes
    assert_hold_between_R7: assert property (@(posedge clk) disable iff (rst)
        !acr_valid |-> ($stable(acr_cts) && $stable(acr_n)));

    // R8: no report while window ends are still being discarded
    assert_discard_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(skip_q) != '0) |-> !acr_valid);

endmodule

// File: rtl/acr_nc_gen.sv
module acr_nc_gen
    import acr_pkg::*;
#(
    parameter int FS_MULT     = 64,
    parameter int SYNC_STAGES = 3,
    parameter int DISCARD     = 3
) (
    input  logic                clk_pix,
    input  logic                rst_pix,
    input  logic                clk_aud,
    input  logic                rst_aud,
    input  logic                reg_we,
    input  logic [15:0]         reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [N_W-1:0]      acr_n,
    output logic [CTS_W-1:0]    acr_cts,
    output logic                acr_valid
);
    n_val_t   n_cur, n_eff;
    acr_cfg_t cfg;
    logic     commit, aud_tog, win_end;

    acr_regfile u_regs (
        .clk    (clk_pix),
        .rst    (rst_pix),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .n_cur  (n_cur),
        .cfg    (cfg),
        .commit (commit)
    );

    assign n_eff = eff_n(n_cur, cfg.halve);

    acr_win_div #(.FS_MULT(FS_MULT)) u_div (
        .clk         (clk_aud),
        .rst         (rst_aud),
        .n_eff_async (n_eff),
        .tog         (aud_tog)
    );

    acr_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk_pix),
        .rst    (rst_pix),
        .tog_in (aud_tog),
        .pulse  (win_end)
    );

    acr_cts_meas #(.DISCARD(DISCARD)) u_meas (
        .clk       (clk_pix),
        .rst       (rst_pix),
        .win_end   (win_end),
        .commit    (commit),
        .n_eff     (n_eff),
        .manual    (cfg.manual),
        .mcts      (cfg.mcts),
        .acr_n     (acr_n),
        .acr_cts   (acr_cts),
        .acr_valid (acr_valid)
    );

    // R6: in manual mode the reported CTS is the software value
    assert_manual_cts_R6: assert property (@(posedge clk_pix) disable iff (rst_pix)
        (acr_valid && cfg.manual && $stable(cfg)) |-> (acr_cts == cfg.mcts));

    // R3: a reported N reflects the halve setting
    assert_eff_n_R3: assert property (@(posedge clk_pix) disable iff (rst_pix)
        (acr_valid && $stable(cfg) && $stable(n_cur)) |-> (acr_n == eff_n(n_cur, cfg.halve)));

endmodule

// File: tb/tb_acr_nc_gen.sv
module tb_acr_nc_gen;
    logic        clk_pix = 1'b0;
    logic        clk_aud = 1'b0;
    logic        rst_pix = 1'b1;
    logic        rst_aud = 1'b1;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [19:0] acr_n, acr_cts;
    logic        acr_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    acr_nc_gen dut (
        .clk_pix(clk_pix), .rst_pix(rst_pix), .clk_aud(clk_aud), .rst_aud(rst_aud),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .acr_n(acr_n), .acr_cts(acr_cts), .acr_valid(acr_valid)
    );

    // 250 MHz pixel clock; audio clock 50 MHz offset by 1 ns
    always #2 clk_pix = ~clk_pix;
    initial begin
        #1;
        forever #10 clk_aud = ~clk_aud;
    end

    // Audio cycle = 5 pixel cycles, FS_MULT=64: CTS = (N_eff/2)*5
    localparam int NV = 6;
    localparam int V_N    [NV] = '{256, 512, 1024, 384, 320, 384};
    localparam int V_CTRL [NV] = '{8'h00, 8'h00, 8'h20, 8'h00, 8'h00, 8'h11};
    localparam int V_MC   [NV] = '{0, 0, 0, 0, 0, 20'h12345};
    localparam int V_EN   [NV] = '{256, 512, 512, 384, 320, 384};
    localparam int V_EC   [NV] = '{640, 1280, 1280, 960, 800, 20'h12345};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk_pix);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk_pix);
        reg_we = 1'b0;
    endtask

    task automatic wait_valid(input int limit, output bit got, output int elapsed);
        got = 0;
        elapsed = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk_pix);
            elapsed++;
            if (acr_valid) begin
                got = 1;
                break;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk_pix);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit got;
        int el;
        int cnt;
        logic [19:0] hn, hc;

        repeat (20) @(negedge clk_pix);
        rst_pix = 1'b0;
        rst_aud = 1'b0;
        @(negedge clk_pix);
        // R10: reset state
        check(acr_n == 0, "R10 n", acr_n, 0);
        check(acr_cts == 0, "R10 cts", acr_cts, 0);
        check(acr_valid == 0, "R10 valid", acr_valid, 0);

        for (int v = 0; v < NV; v++) begin
            wr(16'h3200, 8'(V_N[v]));
            wr(16'h3201, 8'(V_N[v] >> 8));
            wr(16'h3202, 8'(V_N[v] >> 16));
            wr(16'h3203, 8'(V_MC[v]));
            wr(16'h3204, 8'(V_MC[v] >> 8));
            wr(16'h3205, 8'(V_CTRL[v] | ((V_MC[v] >> 16) & 'hF)));
            wait_valid(20000, got, el);
            check(got, "R7 strobe seen", int'(got), 1);
            if (v == 0) check(el >= 1280, "R8 early report", el, 1280);
            check(acr_n == V_EN[v], "R1/R3 n", acr_n, V_EN[v]);
            check(acr_cts == V_EC[v], "R5/R6 cts", acr_cts, V_EC[v]);
            hn = acr_n; hc = acr_cts;
            @(negedge clk_pix);
            check(acr_valid == 0, "R7 one-cycle", acr_valid, 0);
            repeat (100) @(negedge clk_pix);
            check(acr_n == hn && acr_cts == hc && !acr_valid, "R7 hold", acr_cts, hc);
        end

        // R1: staged bytes without top write do not change N
        wr(16'h3200, 8'h00);
        wr(16'h3201, 8'h02);
        wait_valid(20000, got, el);
        check(got && acr_n == 384, "R1 staged only", acr_n, 384);
        check(acr_cts == 20'h12345, "R6 manual kept", acr_cts, 20'h12345);

        // R11: stray addresses ignored
        wr(16'h3206, 8'hFF);
        wr(16'h3100, 8'h3F);
        wr(16'h0202, 8'h01);
        wait_valid(20000, got, el);
        check(got && acr_n == 384, "R11 n", acr_n, 384);
        check(acr_cts == 20'h12345, "R11 cts", acr_cts, 20'h12345);

        // R2: control commit back to automatic; R1: top write commits staged 0x0200
        wr(16'h3205, 8'h00);
        wr(16'h3202, 8'h00);
        wait_valid(20000, got, el);
        check(got && acr_n == 512, "R1 commit", acr_n, 512);
        check(acr_cts == 1280, "R2 auto restored", acr_cts, 1280);

        // R9: N=1 gives a zero-length window: no strobes
        wr(16'h3200, 8'h01);
        wr(16'h3201, 8'h00);
        wr(16'h3202, 8'h00);
        cnt = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk_pix);
            if (acr_valid) cnt++;
        end
        check(cnt == 0, "R9 no strobe", cnt, 0);
        check(acr_n == 512 && acr_cts == 1280, "R7 hold idle", acr_n, 512);

        finish_run();
    end
endmodule